// File: doc/BRIEF.md
# Synchronous Burst SRAM with Dual Address Strobes

This block is a clocked single-port memory with a processor-style bus front end. A new address enters on a rising clock edge when one of two active-low strobes is low: a processor strobe or a controller strobe. Three chip enables decide whether that load selects or deselects the device. After a load, an active-low advance input steps the two low address bits through a four-word burst. The burst order is linear or interleaved, picked by a static mode input.

Writes are global (all byte lanes) or per byte lane. Read data is registered and comes out one clock after its address. The data output carries a drive-enable flag that stands in for a tri-state buffer. That flag is gated by an asynchronous active-low output enable, and it is held off for the first read clock after the device leaves the deselected state.

The chip enables are looked at only on load cycles. The selected or deselected state they set carries through every following advance and idle cycle until the next load. The data pins are plain control-style signals with no handshake: the bus protocol is cycle-exact and has no back-pressure.

Top module: `sbs_burst_sram`

## Requirements
- R1: On a clock edge where a load occurs, the address input is captured as the current access address, and its two low bits seed the burst sequence at beat 0. A load occurs when the processor strobe is low with enable-1 low, or when the controller strobe is low.
- R2: When both strobes are low and enable-1 is low, only the processor strobe takes effect. A processor-strobe load is always a read: any write request in that cycle is ignored and the addressed word is unchanged.
- R3: The processor strobe has no effect at all while enable-1 is high, and address, burst position and selection are kept. The controller strobe is not gated this way: with enable-1 high it still loads, and that load deselects.
- R4: Selection is set on load edges only: selected when enable-1 is low, enable-2 is high and enable-3 is low, deselected otherwise. On non-load cycles the enables are ignored and the selection is kept.
- R5: When the global write input is low on a selected, non-processor-load edge, all four byte lanes are written, whatever the byte-write enable and the lane selects are.
- R6: With global write high, a byte write needs the byte-write enable low. Lane i (bits 8i+7..8i) is written when lane-select bit i is low. With the byte-write enable high, no lane is written and the cycle is a read.
- R7: Each non-load edge with advance low, while selected, moves to the next beat. The burst position counts 0,1,2,3 and then wraps to 0. Its low address bits are base+count mod 4 when the mode input is 1 (linear), and base XOR count when it is 0 (interleaved). The upper address bits do not change.
- R8: The word read at the address accessed on edge k is presented on the data output after edge k+1. The drive flag is high only while output enable is low.
- R9: For the clock after an edge that moves the device from deselected to selected, the drive flag stays low even with output enable low.
- R10: While deselected there is no array access: no write takes effect, including a write requested on the deselecting load, and the drive flag stays low.
- R11: After reset the device is deselected and the drive flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, sampled on load edges |
| strobe_proc_n | input | 1 | Processor address strobe, active low |
| strobe_ctrl_n | input | 1 | Controller address strobe, active low |
| en1_n | input | 1 | Chip enable 1, active low, also gates the processor strobe |
| en2 | input | 1 | Chip enable 2, active high |
| en3_n | input | 1 | Chip enable 3, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwr_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES | Per-lane byte selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_linear | input | 1 | Burst order: 1 linear, 0 interleaved (static) |
| wdata | input | 8*LANES | Write data |
| rdata | output | 8*LANES | Registered read data |
| rdata_drive | output | 1 | High when the data bus is driven, low for high impedance |

## Verification
The hardest case to reach from the ports is a processor strobe and a controller strobe arriving together with a write request, because the winner only shows in whether the array changed. The bench first writes a known word through the controller strobe. It then presents both strobes with the global write low and different data, and checks the read-back of the old word. A second hard case is the output-enable mask. It appears only on the first clock after a deselected-to-selected transition, so the bench deselects through a controller-strobe load with enable-2 low and then reloads with output enable already low.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int LANE_W  = 8;
  localparam int BURST_W = 2;

  typedef logic [BURST_W-1:0] beat_t;

  // Low address bits of a burst beat for either ordering.
  function automatic beat_t beat_addr(input beat_t base, input beat_t cnt, input logic linear);
    beat_t r;
    if (linear) r = beat_t'(base + cnt);
    else        r = base ^ cnt;
    return r;
  endfunction
endpackage

// File: rtl/sbs_addr_ctrl.sv
module sbs_addr_ctrl
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe_proc_n,
  input  logic              strobe_ctrl_n,
  input  logic              en1_n,
  input  logic              en2,
  input  logic              en3_n,
  input  logic              adv_n,
  input  logic              burst_linear,
  output logic              load_proc,
  output logic              sel_next,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] acc_q,
  output logic              sel_q,
  output logic              first_q
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic              take_ctrl, load_any, enables_ok;
  logic [ADDR_W-1:0] base_q, base_next;
  beat_t             cnt_q, cnt_next;

  // Processor strobe only counts with enable-1 low; it outranks the controller strobe.
  assign load_proc  = ~strobe_proc_n & ~en1_n;
  assign take_ctrl  = ~strobe_ctrl_n & ~load_proc;
  assign load_any   = load_proc | take_ctrl;
  assign enables_ok = ~en1_n & en2 & ~en3_n;

  always_comb begin
    sel_next  = sel_q;
    base_next = base_q;
    cnt_next  = cnt_q;
    if (load_any) begin
      sel_next  = enables_ok;
      base_next = addr;
      cnt_next  = '0;
    end else if (sel_q && !adv_n) begin
      cnt_next  = beat_t'(cnt_q + 1'b1);
    end
  end

  assign acc_addr = {base_next[ADDR_W-1 -: HI_W],
                     beat_addr(base_next[BURST_W-1:0], cnt_next, burst_linear)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      cnt_q   <= '0;
      acc_q   <= '0;
      sel_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      base_q  <= base_next;
      cnt_q   <= cnt_next;
      acc_q   <= acc_addr;
      sel_q   <= sel_next;
      first_q <= sel_next & ~sel_q;
    end
  end
endmodule

// File: rtl/sbs_wr_decode.sv
module sbs_wr_decode #(
  parameter int LANES = 4
) (
  input  logic             gwr_n,
  input  logic             bwr_n,
  input  logic [LANES-1:0] bsel_n,
  output logic [LANES-1:0] lane_we,
  output logic             wr_req
);
  // Global write overrides everything; otherwise byte-write enable gates each lane select.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = ~gwr_n | (~bwr_n & ~bsel_n[g]);
  end

  assign wr_req = |lane_we;
endmodule

// File: rtl/sbs_mem.sv
module sbs_mem
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic [LANES-1:0]          we,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         raddr,
  output logic [LANES*LANE_W-1:0]   rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic [LANE_W-1:0] ram [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[g]) ram[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rd_en) rd_q <= ram[raddr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/sbs_burst_sram.sv
module sbs_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe_proc_n,
  input  logic              strobe_ctrl_n,
  input  logic              en1_n,
  input  logic              en2,
  input  logic              en3_n,
  input  logic              adv_n,
  input  logic              gwr_n,
  input  logic              bwr_n,
  input  logic [LANES-1:0]  bsel_n,
  input  logic              oe_n,
  input  logic              burst_linear,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_drive
);
  logic              load_proc, sel_next, sel_q, first_q, wr_req, wr_now, wr_q;
  logic [ADDR_W-1:0] acc_addr, acc_q;
  logic [LANES-1:0]  lane_we, lane_en;

  sbs_addr_ctrl #(.ADDR_W(ADDR_W)) u_addr (
    .clk, .rst_n, .addr, .strobe_proc_n, .strobe_ctrl_n,
    .en1_n, .en2, .en3_n, .adv_n, .burst_linear,
    .load_proc, .sel_next, .acc_addr, .acc_q, .sel_q, .first_q
  );

  sbs_wr_decode #(.LANES(LANES)) u_wdec (
    .gwr_n, .bwr_n, .bsel_n, .lane_we, .wr_req
  );

  // Processor-strobe loads are read starts; no access of any kind while deselected.
  assign wr_now  = sel_next & ~load_proc & wr_req;
  assign lane_en = wr_now ? lane_we : '0;

  sbs_mem #(.ADDR_W(ADDR_W), .LANES(LANES)) u_mem (
    .clk, .we(lane_en), .waddr(acc_addr), .wdata,
    .rd_en(sel_q), .raddr(acc_q), .rdata
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= wr_now;
  end

  assign rdata_drive = ~oe_n & sel_q & ~first_q & ~wr_q;
endmodule

// File: rtl/sbs_burst_sram_chk.sv
module sbs_burst_sram_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              strobe_proc_n,
  input logic              strobe_ctrl_n,
  input logic              en1_n,
  input logic              en2,
  input logic              en3_n,
  input logic              adv_n,
  input logic              rdata_drive,
  input logic [ADDR_W-1:0] acc_q,
  input logic              sel_q
);
  // R1: a load captures the presented address as the access address
  p_load_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((!strobe_proc_n && !en1_n) || !strobe_ctrl_n) |=> (acc_q == $past(addr)));

  // R4: without a load the selection is kept whatever the enables do
  p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((strobe_proc_n || en1_n) && strobe_ctrl_n) |=> (sel_q == $past(sel_q)));

  // R7: an advance moves the low bits and leaves the upper bits alone
  p_burst_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((strobe_proc_n || en1_n) && strobe_ctrl_n && !adv_n && sel_q) |=>
      (acc_q[ADDR_W-1:2] == $past(acc_q[ADDR_W-1:2]) && acc_q[1:0] != $past(acc_q[1:0])));

  // R9: the first clock after becoming selected never drives the bus
  p_oe_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_q) |-> !rdata_drive);

  // R10: a deselecting load leaves the bus undriven
  p_desel_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (((!strobe_proc_n && !en1_n) || !strobe_ctrl_n) && !(!en1_n && en2 && !en3_n)) |=> !rdata_drive);
endmodule

bind sbs_burst_sram sbs_burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .strobe_proc_n(strobe_proc_n),
  .strobe_ctrl_n(strobe_ctrl_n), .en1_n(en1_n), .en2(en2), .en3_n(en3_n),
  .adv_n(adv_n), .rdata_drive(rdata_drive), .acc_q(acc_q), .sel_q(sel_q)
);

// File: tb/sbs_burst_sram_tb.sv
module sbs_burst_sram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int LN = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          strobe_proc_n, strobe_ctrl_n, en1_n, en2, en3_n, adv_n;
  logic          gwr_n, bwr_n, oe_n, burst_linear;
  logic [LN-1:0] bsel_n;
  logic [DW-1:0] wdata, rdata;
  logic          rdata_drive;

  logic [DW-1:0] model [1 << AW];
  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbs_burst_sram #(.ADDR_W(AW), .LANES(LN)) u_dut (
    .clk, .rst_n, .addr, .strobe_proc_n, .strobe_ctrl_n, .en1_n, .en2, .en3_n,
    .adv_n, .gwr_n, .bwr_n, .bsel_n, .oe_n, .burst_linear, .wdata, .rdata, .rdata_drive
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    strobe_proc_n = 1'b1; strobe_ctrl_n = 1'b1; adv_n = 1'b1;
    gwr_n = 1'b1; bwr_n = 1'b1; bsel_n = '1;
    en1_n = 1'b0; en2 = 1'b1; en3_n = 1'b0;
  endtask

  task automatic write_ctrl(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic gw, input logic bw, input logic [LN-1:0] bs);
    idle();
    strobe_ctrl_n = 1'b0; addr = a; wdata = d; gwr_n = gw; bwr_n = bw; bsel_n = bs;
    step();
    if (!gw) model[a] = d;
    else if (!bw)
      for (int i = 0; i < LN; i++)
        if (!bs[i]) model[a][i*8 +: 8] = d[i*8 +: 8];
    idle();
  endtask

  task automatic read_chk(input logic [AW-1:0] a, input string req);
    idle();
    strobe_proc_n = 1'b0; addr = a;
    step();
    idle();
    step();
    chk({req, " drive"}, DW'(rdata_drive), DW'(1));
    chk({req, " data"}, rdata, model[a]);
  endtask

  task automatic deselect();
    idle();
    strobe_ctrl_n = 1'b0; en2 = 1'b0;
    step();
    idle();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    chk("R11 drive in reset", DW'(rdata_drive), '0);
    rst_n = 1'b1;
    step();
    chk("R11 drive after reset", DW'(rdata_drive), '0);
  endtask

  task automatic t_global_write();
    write_ctrl(10'h010, 32'hCAFE_F00D, 1'b0, 1'b1, 4'hF);
    read_chk(10'h010, "R5 global no lane selects");
    write_ctrl(10'h010, 32'h1234_5678, 1'b0, 1'b0, 4'b1110);
    read_chk(10'h010, "R5 global overrides lane selects");
    read_chk(10'h010, "R1 reload same address");
  endtask

  task automatic t_byte_write();
    write_ctrl(10'h020, 32'h1122_3344, 1'b0, 1'b1, 4'hF);
    write_ctrl(10'h020, 32'hAABB_CCDD, 1'b1, 1'b0, 4'b1010);
    read_chk(10'h020, "R6 lanes 0 and 2");
    chk("R6 merged value", model[10'h020], 32'h11BB_33DD);
    write_ctrl(10'h020, 32'h0000_0000, 1'b1, 1'b1, 4'b0000);
    read_chk(10'h020, "R6 byte enable high no write");
  endtask

  task automatic t_priority();
    write_ctrl(10'h030, 32'h5A5A_0001, 1'b0, 1'b1, 4'hF);
    idle();
    strobe_proc_n = 1'b0; strobe_ctrl_n = 1'b0; addr = 10'h030;
    gwr_n = 1'b0; wdata = 32'hDEAD_BEEF;
    step();
    idle();
    step();
    chk("R2 processor wins drive", DW'(rdata_drive), DW'(1));
    chk("R2 processor wins no write", rdata, 32'h5A5A_0001);
  endtask

  task automatic t_ce1_gate();
    write_ctrl(10'h040, 32'h0000_0040, 1'b0, 1'b1, 4'hF);
    write_ctrl(10'h050, 32'h0000_0050, 1'b0, 1'b1, 4'hF);
    read_chk(10'h040, "R1 load 0x40");
    strobe_proc_n = 1'b0; en1_n = 1'b1; addr = 10'h050;
    step();
    idle();
    step();
    chk("R3 ignored strobe keeps address", rdata, 32'h0000_0040);
    chk("R3 ignored strobe keeps select", DW'(rdata_drive), DW'(1));
    strobe_ctrl_n = 1'b0; en1_n = 1'b1; addr = 10'h050;
    step();
    idle();
    #1;
    chk("R3 controller strobe loads and deselects", DW'(rdata_drive), '0);
  endtask

  task automatic t_burst(input logic lin);
    logic [1:0] ord;
    burst_linear = lin;
    for (int i = 0; i < 4; i++)
      write_ctrl(AW'(10'h080 + i), 32'hB000_0000 | (i + 1) | (lin ? 32'h100 : 32'h200), 1'b0, 1'b1, 4'hF);
    idle();
    strobe_proc_n = 1'b0; addr = 10'h081;
    step();
    idle();
    adv_n = 1'b0; en1_n = 1'b1; en2 = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      ord = lin ? 2'(2'd1 + 2'(i)) : (2'd1 ^ 2'(i));
      chk(lin ? "R7 linear beat" : "R7 interleaved beat", rdata, model[10'h080 + ord]);
      chk("R4 enables ignored mid burst", DW'(rdata_drive), DW'(1));
    end
    adv_n = 1'b1;
    step();
    chk("R7 wrap to first beat", rdata, model[10'h081]);
    idle();
  endtask

  task automatic t_oe_mask();
    deselect();
    oe_n = 1'b0;
    strobe_proc_n = 1'b0; addr = 10'h020;
    step();
    idle();
    #1;
    chk("R9 masked first clock", DW'(rdata_drive), '0);
    step();
    chk("R8 data one clock later", rdata, model[10'h020]);
    chk("R8 drive with oe low", DW'(rdata_drive), DW'(1));
    oe_n = 1'b1;
    #1;
    chk("R8 no drive with oe high", DW'(rdata_drive), '0);
    oe_n = 1'b0;
    #1;
  endtask

  task automatic t_deselect_write();
    write_ctrl(10'h070, 32'h0707_0707, 1'b0, 1'b1, 4'hF);
    idle();
    strobe_ctrl_n = 1'b0; en3_n = 1'b1; addr = 10'h070; gwr_n = 1'b0; wdata = 32'hFFFF_0000;
    step();
    idle();
    #1;
    chk("R10 deselected no drive", DW'(rdata_drive), '0);
    step();
    chk("R10 still no drive", DW'(rdata_drive), '0);
    read_chk(10'h070, "R10 deselected write ignored");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; oe_n = 1'b0; burst_linear = 1'b1; addr = '0; wdata = '0;
    idle();
    for (int i = 0; i < (1 << AW); i++) model[i] = '0;
    t_reset();
    t_global_write();
    t_byte_write();
    t_priority();
    t_ce1_gate();
    t_burst(1'b1);
    t_burst(1'b0);
    t_oe_mask();
    t_deselect_write();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule